// File: doc/BRIEF.md
# Per-Lane Control Register Bank

This block keeps three byte-wide control registers for an eight-channel signal-conditioning device. Each register holds one bit per channel. One register holds a restart flag per channel, one a power switch and one a receiver-detect enable. A plain byte-wide register port carries reads and writes, standing in for the serial management bus. The stored power and detect-enable bits drive the per-channel outputs directly.

A small boot state machine has two states. `BOOT_SAMPLE` is entered by asynchronous reset. In that state, on the first clock after reset is released, the restart and detect-enable registers take their values from strap pins, and the state moves to `BOOT_RUN` (transition *strap captured*). `BOOT_RUN` is left only by reset and accepts register writes. While in `BOOT_RUN`, writing a channel's restart bit from 0 to 1 raises a one-cycle restart pulse for that channel. The pulse fires only if the channel is powered and its detection is enabled at the time of the write.

Top module: `lane_ctl_bank`

## Requirements
- R1: While reset is asserted, the power register (address 6) reads 0xFF, the restart register (address 5) and detect-enable register (address 7) read 0x00, and lane_pwr_dn and lane_restart are 0.
- R2: On the first clock edge after reset deasserts, every restart bit takes the value of strap_rst_n. Detect-enable bits 7, 5, 3 and 1 (channels A0..A3) take strap_rxd_a, and bits 6, 4, 2 and 0 (channels B0..B3) take strap_rxd_b. Straps are not sampled again, and this load makes no restart pulse.
- R3: In BOOT_RUN, a write to address 5, 6 or 7 stores wr_data in that register on the clock edge, and a read of that address returns the stored byte combinationally on rd_data.
- R4: A write to any other address changes no register, and a read of any other address returns 0x00.
- R5: lane_pwr_dn[i] is 1 exactly when power bit i is 0, and lane_det_en[i] equals detect-enable bit i.
- R6: A write to address 5 that sets bit i from a stored 0 to 1 raises lane_restart[i] for exactly the one cycle after that write edge, provided power bit i and detect-enable bit i are both 1.
- R7: A rising restart bit on a channel whose power bit or detect-enable bit is 0 makes no pulse, and the blocked edge is not kept for later.
- R8: Writing 1 over a stored 1, writing 0 over a stored 0, or writing 0 over a stored 1 in the restart register makes no pulse.
- R9: Bit 7 down to bit 0 of every register belong to channels A0, B0, A1, B1, A2, B2, A3 and B3, and the outputs use the same bit order.
- R10: A write presented during the BOOT_SAMPLE cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| strap_rst_n | input | 1 | Strap giving the power-on value of all restart bits |
| strap_rxd_a | input | 1 | Strap giving the power-on detect enable of the A channels |
| strap_rxd_b | input | 1 | Strap giving the power-on detect enable of the B channels |
| wr_en | input | 1 | Write strobe |
| addr | input | 8 | Byte address for reads and writes |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for addr (combinational) |
| lane_pwr_dn | output | 8 | Per-channel power-down, 1 = channel off |
| lane_det_en | output | 8 | Per-channel receiver-detect enable |
| lane_restart | output | 8 | One-cycle receiver-detect restart pulse per channel |

## Verification
Some properties are checked on every cycle:
- A pulse never lasts past one cycle.
- A pulse only appears on a channel whose restart bit is now 1 and whose power and detect bits are set.
- Stray-address writes leave all three registers unchanged and stray-address reads return zero.
- The strap load sets the restart and power registers as specified and produces no pulse.

The bench scenarios cover the rest: which exact channels pulse for a given pattern of blocked and open channels, that a blocked edge is not released later when the channel is enabled, the strap bit ordering across two opposite strap settings, and that a write during the sampling cycle is dropped.

// File: rtl/lane_ctl_pkg.sv
package lane_ctl_pkg;

    typedef enum logic [0:0] {
        BOOT_SAMPLE = 1'b0,
        BOOT_RUN    = 1'b1
    } boot_state_e;

    localparam int NUM_REGS = 3;
    localparam int IDX_RST  = 0;
    localparam int IDX_PWR  = 1;
    localparam int IDX_DET  = 2;

endpackage

// File: rtl/lane_ctl_boot_fsm.sv
module lane_ctl_boot_fsm
    import lane_ctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    output logic strap_load,
    output logic run
);

    boot_state_e state_q;
    boot_state_e state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BOOT_SAMPLE;
        else        state_q <= state_d;
    end

    // next state and outputs
    always_comb begin
        state_d    = state_q;
        strap_load = 1'b0;
        run        = 1'b0;
        unique case (state_q)
            BOOT_SAMPLE: begin
                strap_load = 1'b1;
                state_d    = BOOT_RUN;
            end
            BOOT_RUN: begin
                run = 1'b1;
            end
            default: state_d = BOOT_SAMPLE;
        endcase
    end

endmodule

// File: rtl/lane_ctl_reg.sv
module lane_ctl_reg #(
    parameter int           W         = 8,
    parameter logic [W-1:0] RESET_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_en,
    input  logic [W-1:0] load_val,
    input  logic         wr_en,
    input  logic [W-1:0] wr_val,
    output logic [W-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       q <= RESET_VAL;
        else if (load_en) q <= load_val;
        else if (wr_en)   q <= wr_val;
    end

endmodule

// File: rtl/lane_ctl_restart.sv
module lane_ctl_restart #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_hit,
    input  logic [N-1:0] wr_val,
    input  logic [N-1:0] cur_val,
    input  logic [N-1:0] pwr_on,
    input  logic [N-1:0] det_on,
    output logic [N-1:0] pulse
);

    logic [N-1:0] fire_d;

    // per-channel rising-edge detect, gated by power and detect enable
    for (genvar i = 0; i < N; i++) begin : g_ch
        assign fire_d[i] = wr_hit & wr_val[i] & ~cur_val[i] & pwr_on[i] & det_on[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pulse <= '0;
        else        pulse <= fire_d;
    end

endmodule

// File: rtl/lane_ctl_bank.sv
module lane_ctl_bank
    import lane_ctl_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 8,
    parameter int ADDR_RST = 5,
    parameter int ADDR_PWR = 6,
    parameter int ADDR_DET = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_rst_n,
    input  logic              strap_rxd_a,
    input  logic              strap_rxd_b,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] lane_pwr_dn,
    output logic [DATA_W-1:0] lane_det_en,
    output logic [DATA_W-1:0] lane_restart
);

    localparam int NCH = DATA_W;

    logic strap_load;
    logic run;

    logic [NUM_REGS-1:0] hit;
    logic [DATA_W-1:0]   reg_q    [NUM_REGS];
    logic [DATA_W-1:0]   load_val [NUM_REGS];
    logic [DATA_W-1:0]   det_strap;

    logic [DATA_W-1:0] rst_q;
    logic [DATA_W-1:0] pwr_q;
    logic [DATA_W-1:0] det_q;

    lane_ctl_boot_fsm u_boot (
        .clk        (clk),
        .rst_n      (rst_n),
        .strap_load (strap_load),
        .run        (run)
    );

    assign hit[IDX_RST] = (addr == ADDR_W'(ADDR_RST));
    assign hit[IDX_PWR] = (addr == ADDR_W'(ADDR_PWR));
    assign hit[IDX_DET] = (addr == ADDR_W'(ADDR_DET));

    // odd bit positions are A channels, even positions B channels
    for (genvar c = 0; c < NCH; c++) begin : g_strap
        if (c % 2 == 1) begin : g_a
            assign det_strap[c] = strap_rxd_a;
        end else begin : g_b
            assign det_strap[c] = strap_rxd_b;
        end
    end

    assign load_val[IDX_RST] = {DATA_W{strap_rst_n}};
    assign load_val[IDX_PWR] = {DATA_W{1'b1}};
    assign load_val[IDX_DET] = det_strap;

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
        localparam logic [DATA_W-1:0] RV = (r == IDX_PWR) ? {DATA_W{1'b1}} : '0;
        lane_ctl_reg #(
            .W         (DATA_W),
            .RESET_VAL (RV)
        ) u_reg (
            .clk      (clk),
            .rst_n    (rst_n),
            .load_en  (strap_load),
            .load_val (load_val[r]),
            .wr_en    (run & wr_en & hit[r]),
            .wr_val   (wr_data),
            .q        (reg_q[r])
        );
    end

    assign rst_q = reg_q[IDX_RST];
    assign pwr_q = reg_q[IDX_PWR];
    assign det_q = reg_q[IDX_DET];

    lane_ctl_restart #(
        .N (NCH)
    ) u_restart (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_hit  (run & wr_en & hit[IDX_RST]),
        .wr_val  (wr_data),
        .cur_val (rst_q),
        .pwr_on  (pwr_q),
        .det_on  (det_q),
        .pulse   (lane_restart)
    );

    always_comb begin
        rd_data = '0;
        for (int r = 0; r < NUM_REGS; r++) begin
            if (hit[r]) rd_data = reg_q[r];
        end
    end

    assign lane_pwr_dn = ~pwr_q;
    assign lane_det_en = det_q;

endmodule

// File: rtl/lane_ctl_bank_chk.sv
module lane_ctl_bank_chk #(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 8,
    parameter int ADDR_RST = 5,
    parameter int ADDR_PWR = 6,
    parameter int ADDR_DET = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] rd_data,
    input logic [DATA_W-1:0] lane_restart,
    input logic [DATA_W-1:0] rst_q,
    input logic [DATA_W-1:0] pwr_q,
    input logic [DATA_W-1:0] det_q,
    input logic              strap_load,
    input logic              strap_rst_n
);

    logic stray;
    assign stray = (addr != ADDR_W'(ADDR_RST)) && (addr != ADDR_W'(ADDR_PWR))
                && (addr != ADDR_W'(ADDR_DET));

    assert_pulse_one_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_restart != '0) |=> ((lane_restart & $past(lane_restart)) == '0));

    assert_pulse_bit_now_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((lane_restart & ~rst_q) == '0));

    assert_pulse_qualified_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((lane_restart & ~(pwr_q & det_q)) == '0));

    assert_stray_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && stray) |=> ($stable(rst_q) && $stable(pwr_q) && $stable(det_q)));

    assert_strap_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        strap_load |=> ((rst_q == {DATA_W{$past(strap_rst_n)}}) && (pwr_q == {DATA_W{1'b1}})
                        && (lane_restart == '0)));

    always_comb begin
        if (rst_n && stray) begin
            assert_stray_read_R4: assert (rd_data == '0);
        end
    end

endmodule

bind lane_ctl_bank lane_ctl_bank_chk #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .ADDR_RST (ADDR_RST),
    .ADDR_PWR (ADDR_PWR),
    .ADDR_DET (ADDR_DET)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .addr         (addr),
    .rd_data      (rd_data),
    .lane_restart (lane_restart),
    .rst_q        (rst_q),
    .pwr_q        (pwr_q),
    .det_q        (det_q),
    .strap_load   (strap_load),
    .strap_rst_n  (strap_rst_n)
);

// File: tb/lane_ctl_bank_test.sv
module lane_ctl_bank_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       strap_rst_n = 1'b0;
    logic       strap_rxd_a = 1'b0;
    logic       strap_rxd_b = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] addr = 8'h00;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic [7:0] lane_pwr_dn;
    logic [7:0] lane_det_en;
    logic [7:0] lane_restart;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    lane_ctl_bank uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .strap_rst_n  (strap_rst_n),
        .strap_rxd_a  (strap_rxd_a),
        .strap_rxd_b  (strap_rxd_b),
        .wr_en        (wr_en),
        .addr         (addr),
        .wr_data      (wr_data),
        .rd_data      (rd_data),
        .lane_pwr_dn  (lane_pwr_dn),
        .lane_det_en  (lane_det_en),
        .lane_restart (lane_restart)
    );

    task automatic check8(input string req, input string what,
                          input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual 0x%02h expected 0x%02h", req, what, act, exp);
        end
    endtask

    task automatic read_reg(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a;
        #1;
        d = rd_data;
    endtask

    // write at one edge; returns the pulse seen in the following cycle
    task automatic write_reg(input logic [7:0] a, input logic [7:0] d,
                             output logic [7:0] pulse);
        @(negedge clk);
        addr    = a;
        wr_data = d;
        wr_en   = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        pulse = lane_restart;
    endtask

    task automatic t_reset(input logic s_rst, input logic s_a, input logic s_b,
                           input logic [7:0] exp_det);
        logic [7:0] d;
        @(negedge clk);
        rst_n       = 1'b0;
        strap_rst_n = s_rst;
        strap_rxd_a = s_a;
        strap_rxd_b = s_b;
        wr_en       = 1'b0;
        addr        = 8'd6;
        #1;
        check8("R1", "power reg in reset", rd_data, 8'hFF);
        addr = 8'd5;
        #1;
        check8("R1", "restart reg in reset", rd_data, 8'h00);
        addr = 8'd7;
        #1;
        check8("R1", "detect reg in reset", rd_data, 8'h00);
        check8("R1", "pwr_dn in reset", lane_pwr_dn, 8'h00);
        check8("R1", "pulse in reset", lane_restart, 8'h00);
        // release with a write to address 6 pending during the sampling cycle
        @(negedge clk);
        rst_n   = 1'b1;
        addr    = 8'd6;
        wr_data = 8'h00;
        wr_en   = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        check8("R2", "no pulse from strap load", lane_restart, 8'h00);
        #1;
        check8("R10", "write in sampling cycle dropped", rd_data, 8'hFF);
        // straps move after the load: must not be picked up
        strap_rst_n = ~s_rst;
        strap_rxd_a = ~s_a;
        strap_rxd_b = ~s_b;
        repeat (2) @(posedge clk);
        read_reg(8'd5, d);
        check8("R2", "restart reg from strap", d, {8{s_rst}});
        read_reg(8'd7, d);
        check8("R2", "detect reg from straps (R9 order)", d, exp_det);
        check8("R5", "det_en output", lane_det_en, exp_det);
    endtask

    task automatic t_readwrite();
        logic [7:0] d;
        logic [7:0] p;
        write_reg(8'd6, 8'h3C, p);
        read_reg(8'd6, d);
        check8("R3", "power reg readback", d, 8'h3C);
        check8("R5", "pwr_dn output", lane_pwr_dn, 8'hC3);
        write_reg(8'd7, 8'h0F, p);
        read_reg(8'd7, d);
        check8("R3", "detect reg readback", d, 8'h0F);
        check8("R5", "det_en output", lane_det_en, 8'h0F);
        write_reg(8'd6, 8'hFF, p);
        write_reg(8'd7, 8'hFF, p);
        check8("R5", "pwr_dn restored", lane_pwr_dn, 8'h00);
    endtask

    task automatic t_stray();
        logic [7:0] d;
        logic [7:0] p;
        write_reg(8'd4, 8'h00, p);
        write_reg(8'd8, 8'h00, p);
        write_reg(8'hFF, 8'h00, p);
        read_reg(8'd4, d);
        check8("R4", "read addr 4", d, 8'h00);
        read_reg(8'hFF, d);
        check8("R4", "read addr 0xFF", d, 8'h00);
        read_reg(8'd6, d);
        check8("R4", "power reg untouched", d, 8'hFF);
        read_reg(8'd7, d);
        check8("R4", "detect reg untouched", d, 8'hFF);
        read_reg(8'd5, d);
        check8("R4", "restart reg untouched", d, 8'h00);
    endtask

    task automatic t_pulse();
        logic [7:0] p;
        logic [7:0] d;
        write_reg(8'd5, 8'h81, p);
        check8("R6", "pulse on A0 and B3", p, 8'h81);
        @(negedge clk);
        check8("R6", "pulse lasts one cycle", lane_restart, 8'h00);
        read_reg(8'd5, d);
        check8("R3", "restart reg readback", d, 8'h81);
        write_reg(8'd5, 8'h81, p);
        check8("R8", "1 over 1 no pulse", p, 8'h00);
        write_reg(8'd5, 8'h01, p);
        check8("R8", "1 to 0 no pulse", p, 8'h00);
        write_reg(8'd5, 8'h00, p);
        check8("R8", "0 over 0 no pulse", p, 8'h00);
    endtask

    task automatic t_blocked();
        logic [7:0] p;
        write_reg(8'd6, 8'h7F, p);   // A0 powered down
        write_reg(8'd7, 8'hBF, p);   // B0 detect disabled
        write_reg(8'd5, 8'hFF, p);
        check8("R7", "A0 and B0 blocked", p, 8'h3F);
        write_reg(8'd6, 8'hFF, p);
        check8("R7", "no late pulse on power-up", p, 8'h00);
        write_reg(8'd7, 8'hFF, p);
        check8("R7", "no late pulse on detect enable", p, 8'h00);
        write_reg(8'd5, 8'h00, p);
        write_reg(8'd5, 8'h40, p);
        check8("R9", "only B0 (bit 6) pulses", p, 8'h40);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin : main
        repeat (2) @(posedge clk);
        t_reset(1'b1, 1'b1, 1'b0, 8'hAA);
        t_reset(1'b0, 1'b0, 1'b1, 8'h55);
        t_reset(1'b0, 1'b1, 1'b1, 8'hFF);
        t_readwrite();
        t_stray();
        t_pulse();
        t_blocked();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule